// File: doc/BRIEF.md
# Supply-Supervised Reset Sequencer

This block produces the chip-wide reset for power-up and brownout. It takes three inputs: a supply-good flag from an analog comparator, a slow free-running tick clock of about 50 kHz, and the fast system clock. Reset is forced low at once, with no clock needed, whenever the supply flag is low or the block's own init input is low.

After the flag rises, it first has to stay high through a short qualification window. A timeout then runs on the slow tick. Its default terminal count is 256 ticks, which is roughly 5 ms at the nominal tick rate. Any drop of the flag, however short, clears all of this progress.

When the timeout completes, a done indication crosses into the system clock domain. There, a fixed number of system clock edges must be seen, which proves that the clock is running. Only then does reset release, through a short shift register, so the rising edge of reset is aligned to the system clock. A two-bit phase output reports where the sequence stands.

Top module: `supply_reset_seq`

## Requirements
- R1: Whenever `supply_ok` or `init_n` is low, `rst_out_n` is low and `phase` reads 0 at once, with no dependence on either clock running.
- R2: `rst_out_n` never rises before `supply_ok` has been high, without a break, across FILT_TICKS + TIMEOUT_TICKS (default 4 + 256) rising edges of `slow_clk`.
- R3: The first FILT_TICKS (4) rising edges of `slow_clk` after `supply_ok` rises form a qualification window. A high pulse shorter than this window never starts the timeout, and `phase` stays 0 throughout it.
- R4: A low on `supply_ok` of any length, even shorter than one slow tick, restarts the whole sequence from the beginning. This holds during the timeout, during the clock check and after release.
- R5: Once the timeout has completed, `rst_out_n` rises on the 20th rising edge of `sys_clk` that samples the completed timeout. This count is 2 synchroniser stages, plus CLK_CHECK (16) counted edges, plus 2 output stages.
- R6: If `sys_clk` is stopped, `rst_out_n` stays low after the timeout for as long as the clock stays stopped, and `phase` reads 2.
- R7: `phase` encodes the sequence as 0 = supply low or qualifying, 1 = timeout running, 2 = waiting for the system clock, 3 = released.
- R8: Once released, `rst_out_n` stays high until `supply_ok` or `init_n` goes low.
- R9: `rst_out_n` rises only at a rising edge of `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slow_clk | input | 1 | Free-running slow tick clock (about 50 kHz) |
| sys_clk | input | 1 | System clock; may be stopped |
| init_n | input | 1 | Block init, active low, asynchronous |
| supply_ok | input | 1 | Supply-above-threshold flag from the comparator, asynchronous |
| rst_out_n | output | 1 | System reset, active low; asserts asynchronously, deasserts on `sys_clk` |
| phase | output | 2 | Sequence phase: 0 low, 1 timing, 2 waiting for clock, 3 released |

## Verification
The restart of the timeout can fall in the same window as the completion of a later stage. A supply dip can arrive just after the timeout completes, while the done flag is still crossing the synchroniser. A dip can also land within one tick of a new qualification window. The bench provokes these cases with dips of under one tick and of many ticks, placed mid-timeout and after release. A behavioural model counts slow ticks and sampled system edges, and the bench compares `rst_out_n` and `phase` against that model on every system clock. Any early release, or any lost restart, shows up as a mismatch on the same cycle.

// File: rtl/srs_pkg.sv
// Package: shared types for the supply-supervised reset sequencer.
package srs_pkg;
    typedef enum logic [1:0] {
        PH_LOW      = 2'd0,
        PH_TIMING   = 2'd1,
        PH_WAITCLK  = 2'd2,
        PH_RELEASED = 2'd3
    } phase_t;
endpackage

// File: rtl/srs_filter.sv
// Module: srs_filter
// Qualifies a rising supply flag. The async clear already carries the flag,
// so the counter only advances while the flag is high. The output goes high
// once FILT_TICKS slow edges have passed without a break.
// Assumes: arst_n is low whenever the supply flag is low.
module srs_filter #(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic arst_n,
    output logic qual_ok
);
    localparam int FW = $clog2(FILT_TICKS + 1);
    localparam logic [FW-1:0] FMAX = FW'(FILT_TICKS);

    logic [FW-1:0] cnt;

    // Saturating count of slow ticks seen since the flag last rose.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)          cnt <= '0;
        else if (cnt != FMAX) cnt <= cnt + 1'b1;
    end

    assign qual_ok = (cnt == FMAX);
endmodule

// File: rtl/srs_timer.sv
// Module: srs_timer
// Timeout counter in the slow domain. It counts TIMEOUT_TICKS edges while
// enabled, then holds done high until the asynchronous clear.
// Assumes: en stays high once it has risen, until the next clear.
module srs_timer #(
    parameter int TIMEOUT_TICKS = 256
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en,
    output logic done
);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TW-1:0] TMAX = TW'(TIMEOUT_TICKS);

    logic [TW-1:0] cnt;

    // Advance the timeout while qualified; stop at terminal count.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                 cnt <= '0;
        else if (en && cnt != TMAX)  cnt <= cnt + 1'b1;
    end

    assign done = (cnt == TMAX);
endmodule

// File: rtl/srs_sys_release.sv
// Module: srs_sys_release
// System-domain half of the sequencer. It brings the slow-domain done flag
// across with a synchroniser, then counts CLK_CHECK system edges to prove
// the clock is running. Release then ripples through an output shift
// register, so the reset deasserts on a system edge.
// Assumes: done_async is monotonic between clears.
module srs_sys_release #(
    parameter int SYNC_STAGES = 2,
    parameter int CLK_CHECK   = 16,
    parameter int OUT_STAGES  = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic done_async,
    output logic alive,
    output logic rel_n
);
    localparam int CW = $clog2(CLK_CHECK + 1);
    localparam logic [CW-1:0] CMAX = CW'(CLK_CHECK);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [OUT_STAGES-1:0]  out_q;
    logic [CW-1:0]          ccnt;

    // Synchroniser chain for the done flag.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) sync_q[g] <= 1'b0;
                else         sync_q[g] <= (g == 0) ? done_async : sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Clock-alive counter: edges seen after the synchronised done.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                                   ccnt <= '0;
        else if (sync_q[SYNC_STAGES-1] && ccnt != CMAX) ccnt <= ccnt + 1'b1;
    end

    assign alive = (ccnt == CMAX);

    // Output shifter: clears asynchronously, releases on system edges.
    generate
        for (g = 0; g < OUT_STAGES; g++) begin : g_out
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) out_q[g] <= 1'b0;
                else         out_q[g] <= (g == 0) ? alive : out_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign rel_n = out_q[OUT_STAGES-1];
endmodule

// File: rtl/supply_reset_seq.sv
// Module: supply_reset_seq
// Power-on and brownout reset sequencer. The supply flag, combined with the
// block init, clears every register asynchronously. The rest of the sequence
// is qualification and timeout on the slow tick, then a clock-alive check and
// a synchronous release on the system clock.
// Assumes: supply_ok comes from an analog comparator and may chatter.
module supply_reset_seq #(
    parameter int FILT_TICKS    = 4,
    parameter int TIMEOUT_TICKS = 256,
    parameter int SYNC_STAGES   = 2,
    parameter int CLK_CHECK     = 16,
    parameter int OUT_STAGES    = 2
) (
    input  logic       slow_clk,
    input  logic       sys_clk,
    input  logic       init_n,
    input  logic       supply_ok,
    output logic       rst_out_n,
    output logic [1:0] phase
);
    import srs_pkg::*;

    logic    arst_n;
    logic    qual_ok;
    logic    tdone;
    logic    alive;
    phase_t  ph;

    // Any low on either input clears the whole sequence at once.
    assign arst_n = init_n & supply_ok;

    srs_filter #(.FILT_TICKS(FILT_TICKS)) u_filter (
        .clk     (slow_clk),
        .arst_n  (arst_n),
        .qual_ok (qual_ok)
    );

    srs_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk    (slow_clk),
        .arst_n (arst_n),
        .en     (qual_ok),
        .done   (tdone)
    );

    srs_sys_release #(
        .SYNC_STAGES (SYNC_STAGES),
        .CLK_CHECK   (CLK_CHECK),
        .OUT_STAGES  (OUT_STAGES)
    ) u_release (
        .clk        (sys_clk),
        .arst_n     (arst_n),
        .done_async (tdone),
        .alive      (alive),
        .rel_n      (rst_out_n)
    );

    // Phase report from the furthest stage reached.
    always_comb begin
        if (rst_out_n)    ph = PH_RELEASED;
        else if (tdone)   ph = PH_WAITCLK;
        else if (qual_ok) ph = PH_TIMING;
        else              ph = PH_LOW;
    end

    assign phase = ph;
endmodule

// File: rtl/srs_checker.sv
// Module: srs_checker
// Protocol checks for supply_reset_seq, attached with bind.
module srs_checker (
    input logic       slow_clk,
    input logic       sys_clk,
    input logic       supply_ok,
    input logic       init_n,
    input logic       rst_out_n,
    input logic [1:0] phase,
    input logic       arst_n,
    input logic       qual_ok,
    input logic       tdone,
    input logic       alive
);
    AST_LOW_FORCES_RESET: assert property (@(posedge sys_clk)
        !arst_n |-> (!rst_out_n && phase == 2'd0)); // R1

    AST_RELEASE_NEEDS_TIMEOUT: assert property (@(posedge sys_clk) disable iff (!arst_n)
        rst_out_n |-> tdone); // R2

    AST_TIMEOUT_NEEDS_QUAL: assert property (@(posedge slow_clk) disable iff (!arst_n)
        !qual_ok |-> (!tdone && phase == 2'd0)); // R3

    AST_RELEASE_NEEDS_ALIVE: assert property (@(posedge sys_clk) disable iff (!arst_n)
        $rose(rst_out_n) |-> $past(alive)); // R6

    AST_RELEASE_HOLDS: assert property (@(posedge sys_clk) disable iff (!arst_n)
        $past(rst_out_n) |-> rst_out_n); // R8

    AST_PHASE_RELEASED: assert property (@(posedge sys_clk) disable iff (!arst_n)
        rst_out_n |-> phase == 2'd3); // R7
endmodule

bind supply_reset_seq srs_checker u_chk (
    .slow_clk  (slow_clk),
    .sys_clk   (sys_clk),
    .supply_ok (supply_ok),
    .init_n    (init_n),
    .rst_out_n (rst_out_n),
    .phase     (phase),
    .arst_n    (arst_n),
    .qual_ok   (qual_ok),
    .tdone     (tdone),
    .alive     (alive)
);

// File: tb/supply_reset_seq_tb.sv
// Bench for supply_reset_seq: a behavioural model counts ticks and sampled
// system edges, and is compared with the outputs on every system clock.
module supply_reset_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SLOW_HALF  = 40;
    localparam int FILT       = 4;
    localparam int TMO        = 256;
    localparam int REL_EDGES  = 2 + 16 + 2;

    logic       slow_clk = 1'b0;
    logic       sys_raw  = 1'b0;
    logic       sys_en   = 1'b1;
    logic       sys_clk;
    logic       init_n    = 1'b0;
    logic       supply_ok = 1'b0;
    logic       rst_out_n;
    logic [1:0] phase;

    int tests  = 0;
    int fails  = 0;
    int slow_n = 0;
    int k_sys  = 0;

    assign sys_clk = sys_raw & sys_en;

    always #(CLK_PERIOD/2) sys_raw = ~sys_raw;
    initial begin
        #2;
        forever #(SLOW_HALF) slow_clk = ~slow_clk;
    end

    supply_reset_seq u_dut (
        .slow_clk  (slow_clk),
        .sys_clk   (sys_clk),
        .init_n    (init_n),
        .supply_ok (supply_ok),
        .rst_out_n (rst_out_n),
        .phase     (phase)
    );

    function automatic bit m_done();
        return slow_n >= FILT + TMO;
    endfunction

    function automatic logic m_rel();
        return k_sys >= REL_EDGES;
    endfunction

    function automatic logic [1:0] m_phase();
        if (m_rel())            return 2'd3;
        if (m_done())           return 2'd2;
        if (slow_n >= FILT)     return 2'd1;
        return 2'd0;
    endfunction

    // Model: clear on any low of the supply or init.
    always @(negedge supply_ok or negedge init_n) begin
        slow_n = 0;
        k_sys  = 0;
    end

    // Model: count slow ticks with the supply up.
    always @(posedge slow_clk)
        if (supply_ok && init_n && slow_n < FILT + TMO) slow_n++;

    // Model: count system edges that see the completed timeout.
    always @(posedge sys_clk)
        if (supply_ok && init_n && m_done() && k_sys < 1000) k_sys++;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Compare every system clock, away from the active edge.
    always @(negedge sys_clk) begin
        if (rst_out_n !== m_rel())
            check(m_rel() ? "R5 late release" : "R2 early release", 8'(rst_out_n), 8'(m_rel()));
        else
            tests++;
        if (phase !== m_phase())
            check("R7 phase", 8'(phase), 8'(m_phase()));
    end

    task automatic wait_slow(input int n);
        repeat (n) @(posedge slow_clk);
        #7;
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(posedge sys_raw);
        #3;
    endtask

    task automatic stop_sys(input bit run);
        @(negedge sys_raw);
        #1;
        sys_en = run;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // Reset state with init held low.
        #23;
        check("R1 reset rst", 8'(rst_out_n), 8'd0);
        check("R1 reset phase", 8'(phase), 8'd0);
        init_n = 1'b1;
        wait_sys(3);
        check("R1 supply low rst", 8'(rst_out_n), 8'd0);

        // Fast ramp: clean rise, full sequence.
        supply_ok = 1'b1;
        wait_slow(FILT - 1);
        check("R3 window phase", 8'(phase), 8'd0);
        wait_slow(2);
        check("R7 timing phase", 8'(phase), 8'd1);
        wait_slow(TMO);
        wait_sys(2);
        check("R2 waiting after timeout", 8'(rst_out_n), 8'd0);
        wait_sys(REL_EDGES);
        check("R5 released", 8'(rst_out_n), 8'd1);
        check("R7 released phase", 8'(phase), 8'd3);
        wait_slow(40);
        check("R8 stays released", 8'(rst_out_n), 8'd1);

        // Brownout after release: immediate assertion.
        supply_ok = 1'b0;
        #1;
        check("R1 async assert", 8'(rst_out_n), 8'd0);
        check("R1 async phase", 8'(phase), 8'd0);
        wait_slow(5);

        // Slow ramp: comparator chatters with short highs.
        for (int i = 1; i <= 3; i++) begin
            supply_ok = 1'b1;
            wait_slow(i);
            check("R3 chatter phase", 8'(phase), 8'd0);
            supply_ok = 1'b0;
            wait_slow(2);
        end
        supply_ok = 1'b1;

        // Sub-tick dip mid-timeout restarts the count.
        wait_slow(100);
        check("R7 mid timing", 8'(phase), 8'd1);
        supply_ok = 1'b0;
        #30;
        check("R4 short dip rst", 8'(rst_out_n), 8'd0);
        supply_ok = 1'b1;
        wait_slow(FILT + TMO - 1);
        check("R4 restarted timeout", 8'(phase), 8'd1);
        wait_slow(1);

        // Dip just after the timeout, during the clock check.
        wait_sys(5);
        supply_ok = 1'b0;
        #1;
        check("R4 dip during check", 8'(phase), 8'd0);
        wait_slow(1);
        supply_ok = 1'b1;

        // Many-tick dip mid-timeout.
        wait_slow(150);
        supply_ok = 1'b0;
        wait_slow(20);
        check("R4 long dip phase", 8'(phase), 8'd0);
        supply_ok = 1'b1;
        wait_slow(FILT + TMO + 2);
        wait_sys(REL_EDGES + 2);
        check("R5 release after dips", 8'(rst_out_n), 8'd1);

        // Stopped system clock: no release.
        supply_ok = 1'b0;
        wait_slow(2);
        stop_sys(1'b0);
        supply_ok = 1'b1;
        wait_slow(FILT + TMO + 40);
        check("R6 stopped clock rst", 8'(rst_out_n), 8'd0);
        check("R6 stopped clock phase", 8'(phase), 8'd2);
        stop_sys(1'b1);
        wait_sys(REL_EDGES + 2);
        check("R5 release after restart", 8'(rst_out_n), 8'd1);

        // Init pulled low while released.
        init_n = 1'b0;
        #1;
        check("R1 init assert", 8'(rst_out_n), 8'd0);
        wait_sys(3);
        check("R9 no release in init", 8'(rst_out_n), 8'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule